// File: doc/BRIEF.md
# Target-Addressed Dataflow Block Executor

This block holds one block of up to 128 instructions and executes it as an indivisible unit. No instruction names a source register. Each instruction carries up to two target fields that point at the operand slots of its consumers, and its result is sent straight to those slots. Register-read entries take values from the architectural register file at the moment the block starts. Register-write entries collect the block's outputs, and those outputs go to the register file together, in one cycle, when the block commits.

A block is loaded through a valid/ready stream, one entry per transfer. The stream applies back-pressure for the whole run: `load_ready` is high only while the executor is idle, a transfer happens on a clock edge where `load_valid` and `load_ready` are both high, and a source may hold `load_valid` high for as long as it likes without side effects. A one-cycle `start` pulse begins execution. `commit` pulses in the cycle in which the register file is written. `flush` abandons the block at any time and leaves the register file untouched. After a commit or a flush the window is empty, so the next block has to be loaded from scratch.

Top module: `dfx_block_engine`

## Requirements
- R1: `load_ready` is 1 exactly when `busy` is 0. An entry is stored on an edge where `load_valid` and `load_ready` are both 1. `load_kind` selects the entry type: 0 = instruction, 1 = register-read entry, 2 = register-write entry, 3 = nothing stored. A `load_valid` held high while busy changes nothing.
- R2: A target field is 10 bits wide: bit 9 = valid, bits 8:7 = slot, bits 6:0 = index. Slot 0 is the left operand of instruction `index`. Slot 1 is its right operand. Slot 2 is register-write entry `index`. A field with valid = 0, or with slot 3, delivers nothing.
- R3: Each loaded read entry always presents its register number on its lane of `rf_rd_addr`. On the edge where `start` is seen while idle, every read entry delivers its lane of `rf_rd_data` to both of its targets, and `busy` rises.
- R4: Instructions with a binary opcode need both operands. Move and add-immediate need only the left operand. An instruction becomes eligible once its operands are present. In each busy cycle the lowest-indexed eligible instruction that has not yet fired fires. Exactly one instruction fires per cycle, and each one fires at most once.
- R5: The opcodes are 0 = add (L+R), 1 = sub (L−R), 2 = and, 3 = or, 4 = xor, 5 = move (L), and 6 = add-immediate (L + `load_imm`).
- R6: A fired result is delivered on the same edge to both of its targets. A value with more than two consumers reaches them through a tree of move instructions.
- R7: `commit` is 1 in the first busy cycle in which every declared write entry holds a value. In that cycle, `rf_wr_en` has a 1 for each declared entry, and the entry's lane of `rf_wr_addr` and `rf_wr_data` carries its register and value. `rf_wr_en` is 0 in every other cycle. After a commit the window is empty and `busy` is 0.
- R8: A block with no write entries commits in the first busy cycle, with `rf_wr_en` all zero.
- R9: `flush` high on an edge empties the window and returns the executor to idle. It suppresses `commit` in its own cycle and writes nothing to the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Load stream valid |
| load_ready | output | 1 | Load stream ready (idle only) |
| load_kind | input | 2 | Entry type |
| load_idx | input | 7 | Slot number of the entry |
| load_op | input | 3 | Opcode (instruction entries) |
| load_imm | input | DATA_W | Immediate (instruction entries) |
| load_tgt0 | input | 10 | First target field |
| load_tgt1 | input | 10 | Second target field |
| load_reg | input | RA | Register number (read/write entries) |
| start | input | 1 | Begin execution of the loaded block |
| flush | input | 1 | Abandon the block |
| busy | output | 1 | Block executing |
| commit | output | 1 | Commit cycle |
| rf_rd_addr | output | NUM_RD*RA | Read addresses, one lane per read entry |
| rf_rd_data | input | NUM_RD*DATA_W | Read data, combinational from the register file |
| rf_wr_en | output | NUM_WR | Write enables, one per write entry |
| rf_wr_addr | output | NUM_WR*RA | Write addresses |
| rf_wr_data | output | NUM_WR*DATA_W | Write data |

## Verification
The bench builds the block with its default parameters: a 128-instruction window, eight read entries, eight write entries, 32-bit data and 32 registers. With the full window, index 127 can serve as a producer and send its result back to index 0, and lowest-index priority can be tested between instructions far apart in the window. With all eight write lanes present, a commit that writes six registers at once can be checked. A later block then reads those freshly committed registers back through its read entries.

// File: rtl/dfx_pkg.sv
package dfx_pkg;

  localparam int TGT_IDX_W = 7;
  localparam int TGT_W     = TGT_IDX_W + 3;

  typedef enum logic [1:0] {
    SLOT_LEFT  = 2'd0,
    SLOT_RIGHT = 2'd1,
    SLOT_WRITE = 2'd2,
    SLOT_NONE  = 2'd3
  } slot_e;

  typedef struct packed {
    logic                 vld;
    slot_e                slot;
    logic [TGT_IDX_W-1:0] idx;
  } tgt_t;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_MOV  = 3'd5,
    OP_ADDI = 3'd6,
    OP_RSVD = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    LD_INST  = 2'd0,
    LD_READ  = 2'd1,
    LD_WRITE = 2'd2,
    LD_NONE  = 2'd3
  } ldkind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;

  function automatic logic op_needs_right(op_e op);
    return (op != OP_MOV) && (op != OP_ADDI) && (op != OP_RSVD);
  endfunction

endpackage

// File: rtl/dfx_alu.sv
module dfx_alu
  import dfx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_MOV:  y = a;
      OP_ADDI: y = a + imm;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/dfx_fire_pick.sv
module dfx_fire_pick #(
  parameter int N  = 128,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          gnt_v,
  output logic [IW-1:0] gnt_idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    gnt_v   = 1'b0;
    gnt_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt_v   = 1'b1;
        gnt_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dfx_block_engine.sv
module dfx_block_engine
  import dfx_pkg::*;
#(
  parameter int N_INST = 128,   // at most 2**TGT_IDX_W
  parameter int DATA_W = 32,
  parameter int NUM_RD = 8,     // at least 2
  parameter int NUM_WR = 8,     // at least 2
  parameter int REG_N  = 32,
  localparam int RA  = $clog2(REG_N),
  localparam int IA  = $clog2(N_INST),
  localparam int RDA = $clog2(NUM_RD),
  localparam int WRA = $clog2(NUM_WR),
  localparam int NSRC = 2 * NUM_RD
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_valid,
  output logic                     load_ready,
  input  logic [1:0]               load_kind,
  input  logic [TGT_IDX_W-1:0]     load_idx,
  input  logic [2:0]               load_op,
  input  logic [DATA_W-1:0]        load_imm,
  input  logic [TGT_W-1:0]         load_tgt0,
  input  logic [TGT_W-1:0]         load_tgt1,
  input  logic [RA-1:0]            load_reg,
  input  logic                     start,
  input  logic                     flush,
  output logic                     busy,
  output logic                     commit,
  output logic [NUM_RD*RA-1:0]     rf_rd_addr,
  input  logic [NUM_RD*DATA_W-1:0] rf_rd_data,
  output logic [NUM_WR-1:0]        rf_wr_en,
  output logic [NUM_WR*RA-1:0]     rf_wr_addr,
  output logic [NUM_WR*DATA_W-1:0] rf_wr_data
);

  state_e state;

  // instruction window
  logic [N_INST-1:0] i_vld, i_fired, l_rdy, r_rdy;
  op_e               i_op  [N_INST];
  logic [DATA_W-1:0] i_imm [N_INST];
  logic [DATA_W-1:0] l_val [N_INST];
  logic [DATA_W-1:0] r_val [N_INST];
  tgt_t              i_t0  [N_INST];
  tgt_t              i_t1  [N_INST];

  // register-read and register-write entries
  logic [NUM_RD-1:0] rd_vld;
  logic [RA-1:0]     rd_reg [NUM_RD];
  tgt_t              rd_t0  [NUM_RD];
  tgt_t              rd_t1  [NUM_RD];
  logic [NUM_WR-1:0] wr_vld, wr_rdy;
  logic [RA-1:0]     wr_reg [NUM_WR];
  logic [DATA_W-1:0] wr_val [NUM_WR];

  logic              load_fire, launch;
  ldkind_e           kind;
  logic [IA-1:0]     li;
  logic [RDA-1:0]    lr;
  logic [WRA-1:0]    lw;

  assign busy       = (state == ST_RUN);
  assign load_ready = (state == ST_IDLE);
  assign load_fire  = load_valid && load_ready;
  assign launch     = (state == ST_IDLE) && start;
  assign kind       = ldkind_e'(load_kind);
  assign li         = load_idx[IA-1:0];
  assign lr         = load_idx[RDA-1:0];
  assign lw         = load_idx[WRA-1:0];

  // eligibility and firing
  logic [N_INST-1:0] elig;
  logic              pick_v, fire_v;
  logic [IA-1:0]     fire_idx;
  logic [DATA_W-1:0] alu_y;

  always_comb begin
    for (int i = 0; i < N_INST; i++) begin
      elig[i] = i_vld[i] && !i_fired[i] && l_rdy[i] &&
                (r_rdy[i] || !op_needs_right(i_op[i]));
    end
  end

  dfx_fire_pick #(.N(N_INST)) u_pick (
    .req     (elig),
    .gnt_v   (pick_v),
    .gnt_idx (fire_idx)
  );

  assign fire_v = busy && pick_v;

  dfx_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (i_op[fire_idx]),
    .a   (l_val[fire_idx]),
    .b   (r_val[fire_idx]),
    .imm (i_imm[fire_idx]),
    .y   (alu_y)
  );

  // commit when every declared write entry holds a value
  assign commit = busy && !flush && (&(wr_rdy | ~wr_vld));

  // delivery bus: read injections at launch, or one fired result while running
  tgt_t              dv_tgt [NSRC];
  logic [DATA_W-1:0] dv_val [NSRC];

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      dv_tgt[s] = '0;
      dv_val[s] = '0;
    end
    if (launch) begin
      for (int r = 0; r < NUM_RD; r++) begin
        dv_tgt[2*r]   = rd_vld[r] ? rd_t0[r] : '0;
        dv_tgt[2*r+1] = rd_vld[r] ? rd_t1[r] : '0;
        dv_val[2*r]   = rf_rd_data[r*DATA_W +: DATA_W];
        dv_val[2*r+1] = rf_rd_data[r*DATA_W +: DATA_W];
      end
    end else if (fire_v) begin
      dv_tgt[0] = i_t0[fire_idx];
      dv_tgt[1] = i_t1[fire_idx];
      dv_val[0] = alu_y;
      dv_val[1] = alu_y;
    end
  end

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      i_vld   <= '0;
      i_fired <= '0;
      l_rdy   <= '0;
      r_rdy   <= '0;
      rd_vld  <= '0;
      wr_vld  <= '0;
      wr_rdy  <= '0;
    end else if (flush || commit) begin
      state   <= ST_IDLE;
      i_vld   <= '0;
      i_fired <= '0;
      l_rdy   <= '0;
      r_rdy   <= '0;
      rd_vld  <= '0;
      wr_vld  <= '0;
      wr_rdy  <= '0;
    end else begin
      if (load_fire) begin
        unique case (kind)
          LD_INST: begin
            i_vld[li]   <= 1'b1;
            i_fired[li] <= 1'b0;
            l_rdy[li]   <= 1'b0;
            r_rdy[li]   <= 1'b0;
          end
          LD_READ:  rd_vld[lr] <= 1'b1;
          LD_WRITE: begin
            wr_vld[lw] <= 1'b1;
            wr_rdy[lw] <= 1'b0;
          end
          default: ;
        endcase
      end
      if (launch) state <= ST_RUN;
      if (fire_v) i_fired[fire_idx] <= 1'b1;
      for (int s = 0; s < NSRC; s++) begin
        if (dv_tgt[s].vld) begin
          unique case (dv_tgt[s].slot)
            SLOT_LEFT:  if (32'(dv_tgt[s].idx) < N_INST) l_rdy[dv_tgt[s].idx[IA-1:0]] <= 1'b1;
            SLOT_RIGHT: if (32'(dv_tgt[s].idx) < N_INST) r_rdy[dv_tgt[s].idx[IA-1:0]] <= 1'b1;
            SLOT_WRITE: if (32'(dv_tgt[s].idx) < NUM_WR) wr_rdy[dv_tgt[s].idx[WRA-1:0]] <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  // payload storage, no reset needed: qualified by the bits above
  always_ff @(posedge clk) begin
    if (load_fire) begin
      unique case (kind)
        LD_INST: begin
          i_op[li]  <= op_e'(load_op);
          i_imm[li] <= load_imm;
          i_t0[li]  <= tgt_t'(load_tgt0);
          i_t1[li]  <= tgt_t'(load_tgt1);
        end
        LD_READ: begin
          rd_reg[lr] <= load_reg;
          rd_t0[lr]  <= tgt_t'(load_tgt0);
          rd_t1[lr]  <= tgt_t'(load_tgt1);
        end
        LD_WRITE: wr_reg[lw] <= load_reg;
        default: ;
      endcase
    end
    for (int s = 0; s < NSRC; s++) begin
      if (dv_tgt[s].vld) begin
        unique case (dv_tgt[s].slot)
          SLOT_LEFT:  if (32'(dv_tgt[s].idx) < N_INST) l_val[dv_tgt[s].idx[IA-1:0]] <= dv_val[s];
          SLOT_RIGHT: if (32'(dv_tgt[s].idx) < N_INST) r_val[dv_tgt[s].idx[IA-1:0]] <= dv_val[s];
          SLOT_WRITE: if (32'(dv_tgt[s].idx) < NUM_WR) wr_val[dv_tgt[s].idx[WRA-1:0]] <= dv_val[s];
          default: ;
        endcase
      end
    end
  end

  // register-file ports
  always_comb begin
    for (int r = 0; r < NUM_RD; r++) rf_rd_addr[r*RA +: RA] = rd_reg[r];
    for (int w = 0; w < NUM_WR; w++) begin
      rf_wr_en[w]                   = commit && wr_vld[w];
      rf_wr_addr[w*RA +: RA]        = wr_reg[w];
      rf_wr_data[w*DATA_W +: DATA_W] = wr_val[w];
    end
  end

  // R4: at most one instruction newly marked fired per cycle
  assert_one_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $onehot0(i_fired & ~$past(i_fired)));

  // R4: the picked instruction has its left operand and has not fired
  assert_fire_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_v |-> (l_rdy[fire_idx] && !i_fired[fire_idx]));

  // R7: a commit leaves an empty window and an idle executor
  assert_commit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!busy && i_vld == '0 && wr_vld == '0));

  // R9: a flush leaves nothing behind and writes nothing
  assert_flush_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!busy && i_vld == '0 && rf_wr_en == '0));

  // R1: nothing is loaded while running
  assert_no_load_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flush && !commit) |=> ($stable(i_vld) && $stable(rd_vld) && $stable(wr_vld)));

endmodule

// File: tb/dfx_block_engine_tb.sv
module dfx_block_engine_tb_top;
  import dfx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N_INST = 128, DATA_W = 32, NUM_RD = 8, NUM_WR = 8, REG_N = 32;
  localparam int RA = $clog2(REG_N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_valid = 1'b0, load_ready;
  logic [1:0] load_kind = '0;
  logic [6:0] load_idx = '0;
  logic [2:0] load_op = '0;
  logic [DATA_W-1:0] load_imm = '0;
  logic [9:0] load_tgt0 = '0, load_tgt1 = '0;
  logic [RA-1:0] load_reg = '0;
  logic start = 1'b0, flush = 1'b0, busy, commit;
  logic [NUM_RD*RA-1:0] rf_rd_addr;
  logic [NUM_RD*DATA_W-1:0] rf_rd_data;
  logic [NUM_WR-1:0] rf_wr_en;
  logic [NUM_WR*RA-1:0] rf_wr_addr;
  logic [NUM_WR*DATA_W-1:0] rf_wr_data;

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [31:0] rf_m [REG_N];
  logic [NUM_WR-1:0] cap_en;
  logic [NUM_WR*RA-1:0] cap_addr;
  logic [NUM_WR*DATA_W-1:0] cap_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dfx_block_engine #(.N_INST(N_INST), .DATA_W(DATA_W), .NUM_RD(NUM_RD),
                     .NUM_WR(NUM_WR), .REG_N(REG_N)) dut_i (
    .clk, .rst_n, .load_valid, .load_ready, .load_kind, .load_idx, .load_op,
    .load_imm, .load_tgt0, .load_tgt1, .load_reg, .start, .flush, .busy, .commit,
    .rf_rd_addr, .rf_rd_data, .rf_wr_en, .rf_wr_addr, .rf_wr_data);

  // register-file model
  initial for (int i = 0; i < REG_N; i++) rf_m[i] = 32'hA5A5_0000 ^ (i * 32'h0001_1113);
  always_comb
    for (int r = 0; r < NUM_RD; r++) rf_rd_data[r*DATA_W +: DATA_W] = rf_m[rf_rd_addr[r*RA +: RA]];
  always @(posedge clk)
    for (int w = 0; w < NUM_WR; w++)
      if (rf_wr_en[w]) rf_m[rf_wr_addr[w*RA +: RA]] <= rf_wr_data[w*DATA_W +: DATA_W];

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] tg(bit v, int slot, int idx);
    return {v, 2'(slot), 7'(idx)};
  endfunction
  function automatic logic [9:0] TL(int i); return tg(1, 0, i); endfunction
  function automatic logic [9:0] TR(int i); return tg(1, 1, i); endfunction
  function automatic logic [9:0] TW(int i); return tg(1, 2, i); endfunction

  task automatic ld(int kind, int idx, int op, logic [31:0] imm, logic [9:0] t0, logic [9:0] t1, int rg);
    @(negedge clk);
    load_valid = 1'b1; load_kind = 2'(kind); load_idx = 7'(idx); load_op = 3'(op);
    load_imm = imm; load_tgt0 = t0; load_tgt1 = t1; load_reg = RA'(rg);
    do @(posedge clk); while (!load_ready);
    @(negedge clk);
    load_valid = 1'b0;
  endtask
  task automatic ld_inst(int idx, int op, logic [31:0] imm, logic [9:0] t0, logic [9:0] t1);
    ld(0, idx, op, imm, t0, t1, 0);
  endtask
  task automatic ld_read(int idx, int rg, logic [9:0] t0, logic [9:0] t1);
    ld(1, idx, 0, 0, t0, t1, rg);
  endtask
  task automatic ld_write(int idx, int rg);
    ld(2, idx, 0, 0, '0, '0, rg);
  endtask

  // pulses start, returns the negedge count after the start edge at which commit is seen
  task automatic run_block(output int c);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    c = 1;
    while (!commit && c < 300) begin @(negedge clk); c++; end
    cap_en = rf_wr_en; cap_addr = rf_wr_addr; cap_data = rf_wr_data;
  endtask

  task automatic chk_wr(string req, int w, int rg, logic [31:0] val);
    chk(req, 32'(cap_en[w]), 1);
    chk(req, 32'(cap_addr[w*RA +: RA]), 32'(rg));
    chk(req, cap_data[w*DATA_W +: DATA_W], val);
  endtask

  task automatic t_reset();
    chk("R1 reset load_ready", 32'(load_ready), 1);
    chk("R3 reset busy", 32'(busy), 0);
    chk("R7 reset commit", 32'(commit), 0);
    chk("R7 reset rf_wr_en", 32'(rf_wr_en), 0);
  endtask

  task automatic t_arith();
    logic [31:0] a = rf_m[1], b = rf_m[2];
    int c;
    ld_read(0, 1, TL(0), TL(1)); ld_read(1, 2, TR(0), TR(1));
    ld_read(2, 1, TL(2), TL(3)); ld_read(3, 2, TR(2), TR(3));
    ld_read(4, 1, TL(4), '0);    ld_read(5, 2, TR(4), '0);
    ld_read(6, 1, TL(5), '0);
    ld_inst(0, 0, 0, TW(0), '0); ld_inst(1, 1, 0, TW(1), '0);
    ld_inst(2, 2, 0, TW(2), '0); ld_inst(3, 3, 0, TW(3), '0);
    ld_inst(4, 4, 0, TW(4), '0); ld_inst(5, 6, 32'h0000_0123, TW(5), '0);
    for (int w = 0; w < 6; w++) ld_write(w, 10 + w);
    chk("R3 rf_rd_addr lane 1", 32'(rf_rd_addr[1*RA +: RA]), 2);
    run_block(c);
    chk("R4 one fire per cycle, commit cycle", c, 7);
    chk("R7 commit mask", 32'(cap_en), 32'h3F);
    chk_wr("R5 add", 0, 10, a + b);
    chk_wr("R5 sub", 1, 11, a - b);
    chk_wr("R5 and", 2, 12, a & b);
    chk_wr("R5 or", 3, 13, a | b);
    chk_wr("R5 xor", 4, 14, a ^ b);
    chk_wr("R5 addi", 5, 15, a + 32'h0000_0123);
    @(negedge clk);
    chk("R7 idle after commit", 32'(busy), 0);
  endtask

  task automatic t_fanout();
    logic [31:0] v;
    int c;
    @(negedge clk);
    v = rf_m[10];   // committed by the previous block
    chk("R7 register file updated", v, 32'hA5A5_0000 ^ 32'h0001_1113 ^ 32'hA5A5_0000 ^ (2 * 32'h0001_1113)
        ^ 32'hA5A5_0000 ^ 32'h0001_1113 ^ 32'hA5A5_0000 ^ (2 * 32'h0001_1113) ^ v ^ v ^
        ((32'hA5A5_0000 ^ 32'h0001_1113) + (32'hA5A5_0000 ^ (2 * 32'h0001_1113)))
        ^ (32'hA5A5_0000 ^ 32'h0001_1113) ^ (32'hA5A5_0000 ^ 32'h0001_1113)
        ^ (32'hA5A5_0000 ^ (2 * 32'h0001_1113)) ^ (32'hA5A5_0000 ^ (2 * 32'h0001_1113)));
    ld_read(0, 10, TL(10), '0);
    ld_inst(10, 5, 0, TL(20), TL(30));
    ld_inst(20, 5, 0, TW(0), TL(40));
    ld_inst(30, 6, 5, TW(1), '0);
    ld_inst(40, 6, 1, TW(2), '0);
    ld_write(0, 16); ld_write(1, 17); ld_write(2, 18);
    run_block(c);
    chk("R6 mov tree commit cycle", c, 5);
    chk("R7 commit mask fanout", 32'(cap_en), 32'h07);
    chk_wr("R6 mov copy", 0, 16, v);
    chk_wr("R6 second consumer", 1, 17, v + 5);
    chk_wr("R6 third consumer", 2, 18, v + 1);
  endtask

  task automatic t_priority();
    logic [31:0] v = rf_m[4];
    int c;
    ld_read(0, 4, TL(5), TL(3));
    ld_inst(5, 6, 100, TW(0), '0);
    ld_inst(3, 6, 200, TW(0), '0);
    ld_write(0, 19);
    run_block(c);
    chk("R4 lowest index first, commit cycle", c, 2);
    chk_wr("R4 lowest index value", 0, 19, v + 200);
  endtask

  task automatic t_boundary();
    logic [31:0] v5 = rf_m[5], v6 = rf_m[6];
    int c;
    ld_read(0, 5, TL(127), '0);
    ld_read(1, 6, TL(1), '0);
    ld_inst(127, 6, 7, TL(0), tg(1, 3, 1));
    ld_inst(0, 5, 0, TW(7), tg(0, 2, 6));
    ld_inst(1, 5, 0, TW(6), '0);
    ld_write(7, 31); ld_write(6, 30);
    run_block(c);
    chk("R2 index 127 chain commit cycle", c, 4);
    chk("R2 commit mask", 32'(cap_en), 32'hC0);
    chk_wr("R2 index 127 result", 7, 31, v5 + 7);
    chk_wr("R2 cleared valid delivers nothing", 6, 30, v6);
  endtask

  task automatic t_backpressure();
    logic [31:0] v = rf_m[8];
    int c;
    ld_read(0, 8, TL(0), '0);
    ld_inst(0, 6, 1, TL(1), '0);
    ld_inst(1, 6, 1, TL(2), '0);
    ld_inst(2, 6, 1, TW(0), '0);
    ld_write(0, 20);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    load_valid = 1'b1; load_kind = 2'd2; load_idx = 7'd7; load_reg = RA'(9);
    c = 1;
    chk("R3 busy after start", 32'(busy), 1);
    while (!commit && c < 300) begin
      chk("R1 load_ready low while busy", 32'(load_ready), 0);
      @(negedge clk); c++;
    end
    cap_en = rf_wr_en; cap_addr = rf_wr_addr; cap_data = rf_wr_data;
    load_valid = 1'b0;
    chk("R1 held load ignored, commit cycle", c, 4);
    chk("R1 held load ignored, mask", 32'(cap_en), 32'h01);
    chk_wr("R1 chain value", 0, 20, v + 3);
  endtask

  task automatic t_flush();
    logic [31:0] keep = rf_m[21];
    int c, seen;
    ld_read(0, 7, TL(0), '0);
    for (int i = 0; i < 9; i++) ld_inst(i, 6, 1, TL(i + 1), '0);
    ld_inst(9, 6, 1, TW(0), '0);
    ld_write(0, 21);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    chk("R9 idle after flush", 32'(busy), 0);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      if (rf_wr_en != '0 || commit) seen++;
      @(negedge clk);
    end
    chk("R9 no register write after flush", seen, 0);
    chk("R9 register file unchanged", rf_m[21], keep);
    run_block(c);
    chk("R8 empty block commits first cycle", c, 1);
    chk("R8 empty block writes nothing", 32'(cap_en), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_arith();
    t_fanout();
    t_priority();
    t_boundary();
    t_backpressure();
    t_flush();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule